// File: doc/BRIEF.md
# Sub-word to masked-word bus adapter

This block connects a processor-side load/store port to an external peripheral bus that is 32 bits wide and has one select per byte lane. The processor names an access by a device-relative offset, a size (byte, half-word or word) and a direction. The adapter checks the access against the device window, the alignment rule for its size and the set of sizes the instance permits. It adds a fixed base to the offset and turns every accepted access into exactly one full-word bus cycle. The low two address bits are cleared on the bus and carried instead by a four-bit lane mask.

Write data is placed on the lanes that the mask selects and every other lane is driven to zero. Read data is taken from the selected lanes and returned right-justified. For half-words and words, a parameter chooses whether the lower-numbered lane holds the most or the least significant byte. An access that fails a check never reaches the bus: the processor gets a one-cycle response with the error flag set and zero data. A failure reported by the bus is returned the same way.

Top module: `subword_bus_adapter`

## Requirements
- R1: An accepted access produces exactly one bus cycle, whose address is `BASE_ADDR + offset` with bits [1:0] forced to zero. The bus signals stay stable until the bus returns an acknowledge or an error.
- R2: Size code 0 is a byte access. Only lane `a[1:0]` of the full address `a` is selected, where lane k is bus data bits [8k+7:8k]. A read returns that lane's byte in bits [7:0] with zeros above.
- R3: Size code 1 is a half-word access. It selects lanes 0 and 1 when full-address bit 1 is 0, and lanes 2 and 3 when it is 1. A read returns the 16-bit value in bits [15:0] with zeros above.
- R4: Size code 2 is a word access. It selects all four lanes.
- R5: With `BIG_ENDIAN`=0, the lower-numbered lane of a half-word or word carries the less significant byte. With `BIG_ENDIAN`=1, it carries the more significant byte. This holds for both reads and writes.
- R6: A half-word access with offset bit 0 set, or a word access with offset bits [1:0] nonzero, is dropped. No bus cycle occurs, and the response has the error flag set and zero data.
- R7: An access whose offset is greater than or equal to `DEV_SIZE` is dropped in the same way as R6. With `DEV_SIZE`=0 every access is dropped.
- R8: Each size has its own enable parameter. An access of a disabled size, or with size code 3, is dropped in the same way as R6.
- R9: When the bus ends a cycle with an error, the response has the error flag set and read data zero.
- R10: `req_ready` is high after reset and while no bus cycle is open, and it is low while one is open. Every accepted request yields exactly one response pulse of one cycle.
- R11: During a write cycle, every bus data lane whose select is clear is driven to zero. While no cycle is open, the selects and the write data are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Adapter can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 invalid |
| req_offset | input | OFFS_W | Device-relative byte offset |
| req_wdata | input | 32 | Write value, right-justified |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Access dropped or bus failure (with rsp_valid) |
| rsp_rdata | output | 32 | Read value, right-justified; zero on error or write |
| bus_cyc | output | 1 | Bus cycle open |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | ADDR_W | Word-aligned bus address |
| bus_sel | output | 4 | Byte lane selects |
| bus_wdata | output | 32 | Bus write data, unselected lanes zero |
| bus_ack | input | 1 | Bus cycle completed |
| bus_err | input | 1 | Bus cycle failed |
| bus_rdata | input | 32 | Bus read data, valid with bus_ack |

## Verification
The properties assume that `BASE_ADDR` is a multiple of four, so that the offset and the full address agree in their two low bits. They also assume that the peripheral raises acknowledge or error only while a cycle is open, and never both in the same cycle. The bench's bus model answers exactly once, one cycle after it sees an open cycle, and reports an error only for one reserved word. Both adapter instances use a word-aligned base. Requests are offered only while both instances are idle, so the one-outstanding rule is exercised without overlapping traffic.

// File: rtl/sba_pkg.sv
// Package: shared types and helpers of the sub-word bus adapter.
// Assumes a 32-bit data bus with four byte lanes.
package sba_pkg;

    localparam int LANES  = 4;
    localparam int DATA_W = 8 * LANES;

    // Access size code as carried on req_size
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    // Controller state
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUS  = 1'b1
    } adp_state_e;

    // Expand a lane select into a bit mask over the data bus
    function automatic logic [DATA_W-1:0] lane_bits(input logic [LANES-1:0] sel);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < LANES; i++) begin
            m[8*i +: 8] = {8{sel[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/sba_access_check.sv
// Module: sba_access_check
// Decides whether a processor access may go to the bus. It checks the window
// (offset below DEV_SIZE), the alignment for the size, and the per-size enable.
// Assumes the offset is zero-extended to ADDR_W for the range compare.
module sba_access_check
    import sba_pkg::*;
#(
    parameter int              ADDR_W   = 32,
    parameter int              OFFS_W   = 16,
    parameter logic [ADDR_W-1:0] DEV_SIZE = 256,
    parameter bit              EN_BYTE  = 1'b1,
    parameter bit              EN_HALF  = 1'b1,
    parameter bit              EN_WORD  = 1'b1
) (
    input  acc_size_e          size,
    input  logic [OFFS_W-1:0]  offset,
    output logic               ok
);

    logic in_range;
    logic aligned;
    logic size_en;

    // Window check against the configured device size
    always_comb in_range = (ADDR_W'(offset) < DEV_SIZE);

    // Alignment and per-size enable for the requested width
    always_comb begin
        case (size)
            SZ_BYTE: begin aligned = 1'b1;               size_en = EN_BYTE; end
            SZ_HALF: begin aligned = ~offset[0];         size_en = EN_HALF; end
            SZ_WORD: begin aligned = (offset[1:0] == 2'b00); size_en = EN_WORD; end
            default: begin aligned = 1'b0;               size_en = 1'b0;    end
        endcase
    end

    // Final verdict
    always_comb ok = in_range & aligned & size_en;

endmodule

// File: rtl/sba_lane_pack.sv
// Module: sba_lane_pack
// Forms the lane select and places right-justified write data on the lanes,
// ordered by BIG_ENDIAN. Unselected lanes are zero.
// Assumes lo is the low two bits of a word-aligned-base full address.
module sba_lane_pack
    import sba_pkg::*;
#(
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  acc_size_e          size,
    input  logic [1:0]         lo,
    input  logic [DATA_W-1:0]  wdata,
    output logic [LANES-1:0]   sel,
    output logic [DATA_W-1:0]  data
);

    logic [15:0]       half_ord;
    logic [DATA_W-1:0] word_ord;
    logic [DATA_W-1:0] raw;

    // Byte order of half-words and words for the chosen endianness
    generate
        if (BIG_ENDIAN) begin : g_be
            assign half_ord = {wdata[7:0], wdata[15:8]};
            assign word_ord = {wdata[7:0], wdata[15:8], wdata[23:16], wdata[31:24]};
        end else begin : g_le
            assign half_ord = wdata[15:0];
            assign word_ord = wdata;
        end
    endgenerate

    // Lane select per size
    always_comb begin
        case (size)
            SZ_BYTE: sel = 4'b0001 << lo;
            SZ_HALF: sel = lo[1] ? 4'b1100 : 4'b0011;
            SZ_WORD: sel = 4'b1111;
            default: sel = 4'b0000;
        endcase
    end

    // Replicate the value onto every candidate lane position
    always_comb begin
        case (size)
            SZ_BYTE: raw = {LANES{wdata[7:0]}};
            SZ_HALF: raw = {2{half_ord}};
            SZ_WORD: raw = word_ord;
            default: raw = '0;
        endcase
    end

    // Keep only the selected lanes
    always_comb data = raw & lane_bits(sel);

endmodule

// File: rtl/sba_lane_unpack.sv
// Module: sba_lane_unpack
// Extracts the addressed lanes from a bus word and returns them right-justified,
// ordered by BIG_ENDIAN.
// Assumes size and lo are those of the access being completed.
module sba_lane_unpack
    import sba_pkg::*;
#(
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  acc_size_e          size,
    input  logic [1:0]         lo,
    input  logic [DATA_W-1:0]  word,
    output logic [DATA_W-1:0]  value
);

    logic [7:0]        byte_pick;
    logic [15:0]       half_pick;
    logic [15:0]       half_ord;
    logic [DATA_W-1:0] word_ord;

    // Pick the addressed byte and the addressed half-word
    always_comb byte_pick = word[8*lo +: 8];
    always_comb half_pick = lo[1] ? word[31:16] : word[15:0];

    // Endianness variant of the multi-byte results
    generate
        if (BIG_ENDIAN) begin : g_be
            assign half_ord = {half_pick[7:0], half_pick[15:8]};
            assign word_ord = {word[7:0], word[15:8], word[23:16], word[31:24]};
        end else begin : g_le
            assign half_ord = half_pick;
            assign word_ord = word;
        end
    endgenerate

    // Right-justify per size
    always_comb begin
        case (size)
            SZ_BYTE: value = {24'b0, byte_pick};
            SZ_HALF: value = {16'b0, half_ord};
            SZ_WORD: value = word_ord;
            default: value = '0;
        endcase
    end

endmodule

// File: rtl/subword_bus_adapter.sv
// Module: subword_bus_adapter (top)
// Takes one processor access at a time. Accesses that fail the checks are
// answered at once with an error. Accepted ones become one masked full-word bus
// cycle, held open until the bus acknowledges or fails.
// Assumes BASE_ADDR is a multiple of four, and that the bus raises ack or err
// only while bus_cyc is high and never both together.
module subword_bus_adapter
    import sba_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                OFFS_W     = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = 32'h4000_1000,
    parameter logic [ADDR_W-1:0] DEV_SIZE   = 256,
    parameter bit                BIG_ENDIAN = 1'b0,
    parameter bit                EN_BYTE    = 1'b1,
    parameter bit                EN_HALF    = 1'b1,
    parameter bit                EN_WORD    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [OFFS_W-1:0] req_offset,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic              bus_cyc,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [3:0]        bus_sel,
    output logic [31:0]       bus_wdata,
    input  logic              bus_ack,
    input  logic              bus_err,
    input  logic [31:0]       bus_rdata
);

    adp_state_e        state;
    acc_size_e         req_sz;
    acc_size_e         cur_size;
    logic [1:0]        cur_lo;
    logic              acc_ok;
    logic [ADDR_W-1:0] full_addr;
    logic [ADDR_W-1:0] word_addr;
    logic [LANES-1:0]  pack_sel;
    logic [DATA_W-1:0] pack_data;
    logic [DATA_W-1:0] unpack_val;
    logic              accept;
    logic              bus_done;

    // Request decode and address formation
    always_comb req_sz    = acc_size_e'(req_size);
    always_comb full_addr = BASE_ADDR + ADDR_W'(req_offset);
    always_comb word_addr = {full_addr[ADDR_W-1:2], 2'b00};
    always_comb req_ready = (state == ST_IDLE);
    always_comb accept    = req_valid & req_ready;
    always_comb bus_done  = bus_ack | bus_err;

    sba_access_check #(
        .ADDR_W   (ADDR_W),
        .OFFS_W   (OFFS_W),
        .DEV_SIZE (DEV_SIZE),
        .EN_BYTE  (EN_BYTE),
        .EN_HALF  (EN_HALF),
        .EN_WORD  (EN_WORD)
    ) u_check (
        .size   (req_sz),
        .offset (req_offset),
        .ok     (acc_ok)
    );

    sba_lane_pack #(
        .BIG_ENDIAN (BIG_ENDIAN)
    ) u_pack (
        .size  (req_sz),
        .lo    (full_addr[1:0]),
        .wdata (req_wdata),
        .sel   (pack_sel),
        .data  (pack_data)
    );

    sba_lane_unpack #(
        .BIG_ENDIAN (BIG_ENDIAN)
    ) u_unpack (
        .size  (cur_size),
        .lo    (cur_lo),
        .word  (bus_rdata),
        .value (unpack_val)
    );

    // Controller: opens bus cycles, closes them, and issues response pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bus_cyc   <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_sel   <= '0;
            bus_wdata <= '0;
            cur_size  <= SZ_BYTE;
            cur_lo    <= 2'b00;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (acc_ok) begin
                            state     <= ST_BUS;
                            bus_cyc   <= 1'b1;
                            bus_we    <= req_write;
                            bus_addr  <= word_addr;
                            bus_sel   <= pack_sel;
                            bus_wdata <= req_write ? pack_data : '0;
                            cur_size  <= req_sz;
                            cur_lo    <= full_addr[1:0];
                        end else begin
                            rsp_valid <= 1'b1;
                            rsp_err   <= 1'b1;
                        end
                    end
                end
                ST_BUS: begin
                    if (bus_done) begin
                        state     <= ST_IDLE;
                        bus_cyc   <= 1'b0;
                        bus_we    <= 1'b0;
                        bus_addr  <= '0;
                        bus_sel   <= '0;
                        bus_wdata <= '0;
                        rsp_valid <= 1'b1;
                        rsp_err   <= bus_err;
                        rsp_rdata <= (bus_err | bus_we) ? '0 : unpack_val;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sba_checker.sv
// Module: sba_checker
// Temporal properties of the adapter, bound to every instance of the top.
// Assumes a word-aligned base and a bus that answers only inside a cycle.
module sba_checker #(
    parameter int                ADDR_W    = 32,
    parameter int                OFFS_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h4000_1000,
    parameter logic [ADDR_W-1:0] DEV_SIZE  = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_size,
    input logic [OFFS_W-1:0] req_offset,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [31:0]       rsp_rdata,
    input logic              bus_cyc,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [3:0]        bus_sel,
    input logic [31:0]       bus_wdata,
    input logic              bus_ack,
    input logic              bus_err
);

    logic [31:0] sel_bits;
    logic        took;

    // Mask of selected data bits, and a marker for a request taken this cycle
    always_comb sel_bits = {{8{bus_sel[3]}}, {8{bus_sel[2]}}, {8{bus_sel[1]}}, {8{bus_sel[0]}}};
    always_comb took     = req_valid & req_ready;

    AST_ADDR_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> (bus_addr[1:0] == 2'b00) && (bus_sel != 4'b0000)); // R1
    AST_CYC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !bus_ack && !bus_err) |=> bus_cyc && $stable(bus_addr) && $stable(bus_sel) && $stable(bus_wdata)); // R1
    AST_HALF_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && $countones(bus_sel) == 2) |-> (bus_sel == 4'b0011 || bus_sel == 4'b1100)); // R3
    AST_MISALIGN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (took && ((req_size == 2'd1 && req_offset[0]) || (req_size == 2'd2 && req_offset[1:0] != 2'b00)))
        |=> !bus_cyc && rsp_valid && rsp_err); // R6
    AST_RANGE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (took && (ADDR_W'(req_offset) >= DEV_SIZE)) |=> !bus_cyc && rsp_valid && rsp_err); // R7
    AST_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> (bus_addr >= BASE_ADDR) && ((bus_addr - BASE_ADDR) < DEV_SIZE)); // R7
    AST_BAD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (took && req_size == 2'd3) |=> !bus_cyc && rsp_err); // R8
    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == 32'h0)); // R9
    AST_BUS_ERR_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_err) |=> rsp_valid && rsp_err && !bus_cyc); // R9
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> !req_ready); // R10
    AST_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid); // R10
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !took) |=> !rsp_valid); // R10
    AST_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_we) |-> ((bus_wdata & ~sel_bits) == 32'h0)); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cyc |-> (bus_sel == 4'b0000) && (bus_wdata == 32'h0)); // R11

endmodule

bind subword_bus_adapter sba_checker #(
    .ADDR_W    (ADDR_W),
    .OFFS_W    (OFFS_W),
    .BASE_ADDR (BASE_ADDR),
    .DEV_SIZE  (DEV_SIZE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_size   (req_size),
    .req_offset (req_offset),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata),
    .bus_cyc    (bus_cyc),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_sel    (bus_sel),
    .bus_wdata  (bus_wdata),
    .bus_ack    (bus_ack),
    .bus_err    (bus_err)
);

// File: tb/sba_bus_model.sv
// Bench peripheral: 64-word memory answering one cycle after a cycle opens.
// The word at index 63 always answers with an error. Every issued cycle is
// captured for checking.
module sba_bus_model (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cyc,
    input  logic        we,
    input  logic [31:0] addr,
    input  logic [3:0]  sel,
    input  logic [31:0] wdata,
    output logic        ack,
    output logic        err,
    output logic [31:0] rdata,
    output int          issues,
    output logic [31:0] cap_addr,
    output logic [3:0]  cap_sel,
    output logic [31:0] cap_wdata,
    input  logic [5:0]  peek_idx,
    output logic [31:0] peek_word
);
    logic [31:0] mem [64];

    always @(posedge clk) begin
        if (!rst_n) begin
            ack <= 1'b0; err <= 1'b0; rdata <= '0; issues <= 0;
            cap_addr <= '0; cap_sel <= '0; cap_wdata <= '0;
            for (int i = 0; i < 64; i++) mem[i] <= 32'hA500_0000 ^ (i * 32'h0103_0507);
        end else begin
            ack <= 1'b0; err <= 1'b0; rdata <= '0;
            if (cyc && !ack && !err) begin
                issues    <= issues + 1;
                cap_addr  <= addr;
                cap_sel   <= sel;
                cap_wdata <= wdata;
                if (addr[7:2] == 6'h3F) begin
                    err <= 1'b1;
                end else begin
                    ack <= 1'b1;
                    if (we) begin
                        for (int j = 0; j < 4; j++)
                            if (sel[j]) mem[addr[7:2]][8*j +: 8] <= wdata[8*j +: 8];
                    end else begin
                        rdata <= mem[addr[7:2]];
                    end
                end
            end
        end
    end

    assign peek_word = mem[peek_idx];
endmodule

// File: tb/subword_bus_adapter_tb.sv
// Bench: a little-endian instance with all sizes (u_dut) and a big-endian
// instance with byte accesses disabled (u_dut_be) see the same requests.
module subword_bus_adapter_tb;
    localparam logic [31:0] BASE = 32'h4000_1000;
    localparam int          SIZE = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size  = 2'd0;
    logic [15:0] req_offset = 16'd0;
    logic [31:0] req_wdata = 32'd0;
    logic [5:0]  peek_idx = 6'd0;

    logic        le_ready, le_rv, le_re, le_cyc, le_we, le_ack, le_err;
    logic [31:0] le_rd, le_addr, le_wd, le_brd, le_caddr, le_cwd, le_peek;
    logic [3:0]  le_sel, le_csel;
    int          le_iss;
    logic        be_ready, be_rv, be_re, be_cyc, be_we, be_ack, be_err;
    logic [31:0] be_rd, be_addr, be_wd, be_brd, be_caddr, be_cwd, be_peek;
    logic [3:0]  be_sel, be_csel;
    int          be_iss;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    subword_bus_adapter #(.BASE_ADDR(BASE), .DEV_SIZE(SIZE), .BIG_ENDIAN(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(le_ready),
        .req_write(req_write), .req_size(req_size), .req_offset(req_offset), .req_wdata(req_wdata),
        .rsp_valid(le_rv), .rsp_err(le_re), .rsp_rdata(le_rd),
        .bus_cyc(le_cyc), .bus_we(le_we), .bus_addr(le_addr), .bus_sel(le_sel), .bus_wdata(le_wd),
        .bus_ack(le_ack), .bus_err(le_err), .bus_rdata(le_brd));

    subword_bus_adapter #(.BASE_ADDR(BASE), .DEV_SIZE(SIZE), .BIG_ENDIAN(1'b1), .EN_BYTE(1'b0)) u_dut_be (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(be_ready),
        .req_write(req_write), .req_size(req_size), .req_offset(req_offset), .req_wdata(req_wdata),
        .rsp_valid(be_rv), .rsp_err(be_re), .rsp_rdata(be_rd),
        .bus_cyc(be_cyc), .bus_we(be_we), .bus_addr(be_addr), .bus_sel(be_sel), .bus_wdata(be_wd),
        .bus_ack(be_ack), .bus_err(be_err), .bus_rdata(be_brd));

    sba_bus_model u_le_bus (.clk(clk), .rst_n(rst_n), .cyc(le_cyc), .we(le_we), .addr(le_addr),
        .sel(le_sel), .wdata(le_wd), .ack(le_ack), .err(le_err), .rdata(le_brd), .issues(le_iss),
        .cap_addr(le_caddr), .cap_sel(le_csel), .cap_wdata(le_cwd), .peek_idx(peek_idx), .peek_word(le_peek));
    sba_bus_model u_be_bus (.clk(clk), .rst_n(rst_n), .cyc(be_cyc), .we(be_we), .addr(be_addr),
        .sel(be_sel), .wdata(be_wd), .ack(be_ack), .err(be_err), .rdata(be_brd), .issues(be_iss),
        .cap_addr(be_caddr), .cap_sel(be_csel), .cap_wdata(be_cwd), .peek_idx(peek_idx), .peek_word(be_peek));

    // Bytes moved by a size code (0 for the invalid code)
    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 0;
    endfunction

    // Requirement tag explaining whether and why an access is dropped ("" = accepted)
    function automatic string drop_tag(input logic [1:0] sz, input logic [15:0] off, input bit byte_en);
        int n = nbytes(sz);
        if (sz == 2'd3) return "R8";
        if (32'(off) >= SIZE) return "R7";
        if (n > 1 && (int'(off) % n) != 0) return "R6";
        if (sz == 2'd0 && !byte_en) return "R8";
        return "";
    endfunction

    function automatic logic [3:0] exp_sel(input logic [1:0] sz, input logic [15:0] off);
        int n = nbytes(sz);
        int first = int'(off[1:0]) & ~(n - 1);
        logic [3:0] s = '0;
        for (int k = 0; k < n; k++) s[first + k] = 1'b1;
        return s;
    endfunction

    function automatic logic [31:0] exp_bus_wd(input bit be, input logic [1:0] sz, input logic [15:0] off, input logic [31:0] wd);
        int n = nbytes(sz);
        int first = int'(off[1:0]) & ~(n - 1);
        logic [31:0] o = '0;
        for (int k = 0; k < n; k++) o[8*(first+k) +: 8] = wd[8*(be ? n-1-k : k) +: 8];
        return o;
    endfunction

    function automatic logic [31:0] exp_read(input bit be, input logic [1:0] sz, input logic [15:0] off, input logic [31:0] w);
        int n = nbytes(sz);
        int first = int'(off[1:0]) & ~(n - 1);
        logic [31:0] o = '0;
        for (int k = 0; k < n; k++) o[8*(be ? n-1-k : k) +: 8] = w[8*(first+k) +: 8];
        return o;
    endfunction

    function automatic string size_tag(input logic [1:0] sz, input bit be);
        if (be && sz != 2'd0) return "R5";
        return (sz == 2'd0) ? "R2" : (sz == 2'd1) ? "R3" : "R4";
    endfunction

    task automatic chk(input bit ok, input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Verify one instance's outcome of an access
    task automatic judge(input bit be, input bit byte_en, input bit we, input logic [1:0] sz,
                         input logic [15:0] off, input logic [31:0] wd, input logic [31:0] old_word,
                         input bit got, input logic err, input logic [31:0] rd, input int dissue,
                         input logic [31:0] caddr, input logic [3:0] csel, input logic [31:0] cwd,
                         input logic ready_after);
        string dt = drop_tag(sz, off, byte_en);
        bit poison = (off[7:2] == 6'h3F);
        chk(got, "R10", "response seen", 32'(got), 32'd1);
        if (dt != "") begin
            chk(err == 1'b1, dt, "drop error flag", 32'(err), 32'd1);
            chk(rd == 32'h0, dt, "drop read data", rd, 32'h0);
            chk(dissue == 0, dt, "drop bus cycles", 32'(dissue), 32'd0);
        end else begin
            chk(dissue == 1, "R1", "bus cycles", 32'(dissue), 32'd1);
            chk(ready_after == 1'b0, "R10", "ready while cycle open", 32'(ready_after), 32'd0);
            chk(caddr == BASE + {16'h0, off[15:2], 2'b00}, "R1", "bus address", caddr, BASE + {16'h0, off[15:2], 2'b00});
            chk(csel == exp_sel(sz, off), size_tag(sz, be), "lane select", 32'(csel), 32'(exp_sel(sz, off)));
            if (poison) begin
                chk(err == 1'b1 && rd == 32'h0, "R9", "bus error response", {rd[30:0], err}, 32'h1);
            end else begin
                chk(err == 1'b0, size_tag(sz, be), "no error", 32'(err), 32'd0);
                if (we)
                    chk(cwd == exp_bus_wd(be, sz, off, wd), "R11", "bus write data", cwd, exp_bus_wd(be, sz, off, wd));
                else
                    chk(rd == exp_read(be, sz, off, old_word), size_tag(sz, be), "read data", rd, exp_read(be, sz, off, old_word));
            end
        end
    endtask

    task automatic access(input bit we, input logic [1:0] sz, input logic [15:0] off, input logic [31:0] wd);
        int le0, be0;
        logic [31:0] le_old, be_old;
        bit le_got = 1'b0, be_got = 1'b0;
        logic le_e = 1'b0, be_e = 1'b0, le_rdy = 1'b1, be_rdy = 1'b1;
        logic [31:0] le_d = '0, be_d = '0;
        @(negedge clk);
        peek_idx = off[7:2];
        #1;
        le_old = le_peek; be_old = be_peek;
        le0 = le_iss; be0 = be_iss;
        req_valid = 1'b1; req_write = we; req_size = sz; req_offset = off; req_wdata = wd;
        @(posedge clk);
        #1 req_valid = 1'b0;
        for (int c = 0; c < 12 && !(le_got && be_got); c++) begin
            @(negedge clk);
            if (c == 0) begin le_rdy = le_ready; be_rdy = be_ready; end
            if (le_rv && !le_got) begin le_got = 1'b1; le_e = le_re; le_d = le_rd; end
            if (be_rv && !be_got) begin be_got = 1'b1; be_e = be_re; be_d = be_rd; end
        end
        @(negedge clk);
        judge(1'b0, 1'b1, we, sz, off, wd, le_old, le_got, le_e, le_d, le_iss - le0, le_caddr, le_csel, le_cwd, le_rdy);
        judge(1'b1, 1'b0, we, sz, off, wd, be_old, be_got, be_e, be_d, be_iss - be0, be_caddr, be_csel, be_cwd, be_rdy);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R10, R11)
        chk(le_ready == 1'b1 && be_ready == 1'b1, "R10", "ready after reset", {le_ready, be_ready}, 32'h3);
        chk(le_cyc == 1'b0 && le_sel == 4'h0 && le_wd == 32'h0, "R11", "bus quiet after reset", {le_cyc, le_sel}, 32'h0);
        chk(le_rv == 1'b0, "R10", "no response after reset", 32'(le_rv), 32'h0);

        // Byte lanes, each position, write then read (R2, R11)
        for (int b = 0; b < 4; b++) begin
            access(1'b1, 2'd0, 16'h0010 + 16'(b), 32'hFFFF_FF10 + 32'(b));
            access(1'b0, 2'd0, 16'h0010 + 16'(b), 32'h0);
        end
        // Half-words at both positions (R3, R5)
        access(1'b1, 2'd1, 16'h0020, 32'hDEAD_BEEF);
        access(1'b1, 2'd1, 16'h0022, 32'h1234_5678);
        access(1'b0, 2'd1, 16'h0020, 32'h0);
        access(1'b0, 2'd1, 16'h0022, 32'h0);
        // Words (R4, R5)
        access(1'b1, 2'd2, 16'h0030, 32'h0102_0304);
        access(1'b0, 2'd2, 16'h0030, 32'h0);
        // Misaligned (R6)
        access(1'b0, 2'd1, 16'h0021, 32'h0);
        access(1'b1, 2'd2, 16'h0032, 32'hCAFE_F00D);
        access(1'b0, 2'd2, 16'h0031, 32'h0);
        // Window edges (R7)
        access(1'b0, 2'd2, 16'h00FC - 16'h0004, 32'h0);
        access(1'b0, 2'd0, 16'h0100, 32'h0);
        access(1'b1, 2'd2, 16'hFFFC, 32'h5555_AAAA);
        // Invalid size code (R8)
        access(1'b0, 2'd3, 16'h0040, 32'h0);
        // Bus failure on the reserved word (R9)
        access(1'b0, 2'd2, 16'h00FC, 32'h0);
        access(1'b1, 2'd1, 16'h00FE, 32'h7777_8888);

        // Constrained random traffic
        for (int n = 0; n < 500; n++) begin
            logic [1:0]  sz = 2'($urandom_range(0, 3));
            logic [15:0] off = 16'($urandom_range(0, 290));
            bit          we = 1'($urandom_range(0, 1));
            logic [31:0] wd = $urandom;
            if ($urandom_range(0, 3) != 0 && sz != 2'd3) off = off & ~16'(nbytes(sz) - 1);
            access(we, sz, off, wd);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule